// File: doc/BRIEF.md
# Clock-sampled asynchronous SRAM emulator

This block mimics an asynchronous byte-wide static RAM inside a synchronous design. A sample clock observes three active-low strobes (chip select, write enable, output enable), an address and a data-in byte. The block applies the device truth table to decide when a write is in progress and when the data bus is driven. The bidirectional pins are split into a data-in bus, a data-out bus and a drive-enable flag. The host design, or a pad wrapper around it, turns these back into a tri-state pin.

The address space is 17 bits wide, for 128K bytes. The storage behind it is a parameter and defaults to 1K bytes, so the address wraps onto the stored depth. Analog timing becomes whole sample clocks. The bus turn-on delay, the turn-off delay and the data hold after an address change are each a parameter. A separate flag reports any sample in which an outside driver and the emulator both drive the bus.

Top module: `sram_emu`

## Requirements
- R1: While reset is held and in the first sample after it, `dout_en` and `contention` are 0.
- R2: A sample with only `cs_n` low, or only `we_n` low, changes no stored byte.
- R3: A write spans the samples in which `cs_n` and `we_n` are both low, so it starts at whichever strobe falls later. It is committed at the first sample in which either strobe is high. The stored address and byte are those sampled in the last sample of the overlap.
- R4: The stored location is `addr` modulo `MEM_DEPTH`, where `MEM_DEPTH` is a power of two. Addresses that differ only above the low log2(`MEM_DEPTH`) bits name the same byte.
- R5: The drive condition is `cs_n`=0, `oe_n`=0 and `we_n`=1. `dout_en` rises only after the drive condition has held for `TON_CLKS` consecutive samples, and becomes 1 at the clock edge of the last of those samples.
- R6: Once the drive condition fails, `dout_en` stays 1 for `TOFF_CLKS`-1 further samples and is 0 from the edge of sample number `TOFF_CLKS`.
- R7: If `cs_n` falls in the same sample as `we_n` or after it, with the bus released beforehand, `dout_en` stays 0 for the whole write.
- R8: When `we_n` rises to end a write while `cs_n` and `oe_n` are low, `dout_en` turns on `TON_CLKS` samples later and `dout` shows the byte just written.
- R9: When `addr` changes, `dout` keeps its previous value for `HOLD_CLKS` samples, counting the first sample with the new address. The new location's byte appears at the next edge.
- R10: `contention` is 1 in the cycle after a sample in which `ext_drv` and `dout_en` were both 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (17) | Byte address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | DATA_W (8) | Byte driven onto the pins by the outside |
| ext_drv | input | 1 | The outside is driving the pins in this sample |
| dout | output | DATA_W (8) | Byte the emulator presents on the pins |
| dout_en | output | 1 | Emulator drives the pins |
| contention | output | 1 | Both sides drove the pins in the previous sample |

## Verification
Every location of a 64-byte configuration is written with an arithmetic pattern. Writes alternate between write-enable framing and chip-select framing, and they use aliased upper address bits. This separates the two ways a write can end and shows whether the index wraps. A continuous read sweep then steps through every address and checks both the held byte and the new byte at each step, which catches off-by-one hold counts. Directed sequences cover the order of the strobes, a byte that changes mid-write, single-strobe stimulus that must be ignored, the turn-on after a write, and contention with the bus both driven and released.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    // Phase of the emulated data pins
    typedef enum logic [1:0] {
        BUS_RELEASED    = 2'd0,
        BUS_TURNING_ON  = 2'd1,
        BUS_DRIVING     = 2'd2,
        BUS_TURNING_OFF = 2'd3
    } bus_state_e;

endpackage

// File: rtl/sram_emu_strobe.sv
module sram_emu_strobe #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data
);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } strobe_t;

    strobe_t st_d, st_q;
    logic    overlap;

    always_comb begin
        overlap = !cs_n && !we_n;
        st_d        = st_q;
        st_d.active = overlap;
        if (overlap) begin
            st_d.idx  = idx;
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Overlap ended in this sample: commit what the last overlapping sample held
    assign commit      = st_q.active && !overlap;
    assign commit_idx  = st_q.idx;
    assign commit_data = st_q.data;

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_data;
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/sram_emu_drive.sv
module sram_emu_drive
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int TON_CLKS  = 2,
    parameter int TOFF_CLKS = 1,
    parameter int HOLD_CLKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              ext_drv,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              contention
);

    localparam int MAXV  = (TON_CLKS > TOFF_CLKS)
                         ? ((TON_CLKS > HOLD_CLKS) ? TON_CLKS : HOLD_CLKS)
                         : ((TOFF_CLKS > HOLD_CLKS) ? TOFF_CLKS : HOLD_CLKS);
    localparam int CW    = $clog2(MAXV + 2);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] TON_C  = CW'(TON_CLKS);
    localparam logic [CW-1:0] TOFF_C = CW'(TOFF_CLKS);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CLKS);

    typedef struct packed {
        bus_state_e        st;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     hold;
        logic [ADDR_W-1:0] last_addr;
        logic [DATA_W-1:0] data;
        logic              clash;
    } drive_t;

    drive_t dr_d, dr_q;
    logic   rd_ok;
    logic   en_q;

    assign en_q = (dr_q.st == BUS_DRIVING) || (dr_q.st == BUS_TURNING_OFF);

    always_comb begin
        rd_ok = !cs_n && !oe_n && we_n;
        dr_d           = dr_q;
        dr_d.last_addr = addr;
        dr_d.clash     = ext_drv && en_q;

        // Pin phase with turn-on and turn-off counts
        unique case (dr_q.st)
            BUS_RELEASED: begin
                dr_d.cnt = ONE;
                if (rd_ok) dr_d.st = (ONE >= TON_C) ? BUS_DRIVING : BUS_TURNING_ON;
            end
            BUS_TURNING_ON: begin
                if (rd_ok) begin
                    dr_d.cnt = dr_q.cnt + ONE;
                    if (dr_d.cnt >= TON_C) dr_d.st = BUS_DRIVING;
                end else begin
                    dr_d.st = BUS_RELEASED;
                end
            end
            BUS_DRIVING: begin
                if (!rd_ok) begin
                    dr_d.cnt = ONE;
                    dr_d.st  = (ONE >= TOFF_C) ? BUS_RELEASED : BUS_TURNING_OFF;
                end
            end
            BUS_TURNING_OFF: begin
                if (rd_ok) begin
                    dr_d.st = BUS_DRIVING;
                end else begin
                    dr_d.cnt = dr_q.cnt + ONE;
                    if (dr_d.cnt >= TOFF_C) dr_d.st = BUS_RELEASED;
                end
            end
            default: dr_d.st = BUS_RELEASED;
        endcase

        // Output data with hold after an address change
        if (addr != dr_q.last_addr) begin
            if (HOLD_CLKS == 0) begin
                dr_d.data = rd_data;
                dr_d.hold = '0;
            end else begin
                dr_d.hold = HOLD_C - ONE;
            end
        end else if (dr_q.hold != '0) begin
            dr_d.hold = dr_q.hold - ONE;
        end else begin
            dr_d.data = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q    <= '0;
            dr_q.st <= BUS_RELEASED;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign dout       = dr_q.data;
    assign dout_en    = en_q;
    assign contention = dr_q.clash;

endmodule

// File: rtl/sram_emu.sv
module sram_emu #(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 1024,
    parameter int TON_CLKS  = 2,
    parameter int TOFF_CLKS = 1,
    parameter int HOLD_CLKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ext_drv,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              contention
);

    localparam int IDX_W = $clog2(MEM_DEPTH);

    logic              wr_commit;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [IDX_W-1:0]  cur_idx;

    assign cur_idx = addr[IDX_W-1:0];

    sram_emu_strobe #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .we_n        (we_n),
        .idx         (cur_idx),
        .din         (din),
        .commit      (wr_commit),
        .commit_idx  (wr_idx),
        .commit_data (wr_data)
    );

    sram_emu_array #(.DEPTH(MEM_DEPTH), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_commit),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (cur_idx),
        .rd_data (rd_data)
    );

    sram_emu_drive #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .TON_CLKS  (TON_CLKS),
        .TOFF_CLKS (TOFF_CLKS),
        .HOLD_CLKS (HOLD_CLKS)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .rd_data    (rd_data),
        .ext_drv    (ext_drv),
        .dout       (dout),
        .dout_en    (dout_en),
        .contention (contention)
    );

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int HOLD_CLKS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ext_drv,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              contention,
    input logic              commit
);

    // R3
    commit_after_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(!cs_n && !we_n) && (cs_n || we_n)));

    // R5
    turn_on_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(!cs_n && !oe_n && we_n));

    // R6
    turn_off_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_en) |-> !$past(!cs_n && !oe_n && we_n));

    // R10
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (contention == $past(ext_drv && dout_en)));

    generate
        if (HOLD_CLKS > 0) begin : g_hold
            // R9
            addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (addr != $past(addr))) |=> $stable(dout));
        end
    endgenerate

endmodule

bind sram_emu sram_emu_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .HOLD_CLKS (HOLD_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .addr       (addr),
    .ext_drv    (ext_drv),
    .dout       (dout),
    .dout_en    (dout_en),
    .contention (contention),
    .commit     (wr_commit)
);

// File: tb/sram_emu_tb.sv
module sram_emu_tb;

    localparam int AW    = 17;
    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int TON   = 3;
    localparam int TOFF  = 2;
    localparam int HOLD  = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs_n, we_n, oe_n, ext_drv;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en, contention;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sram_emu #(
        .ADDR_W(AW), .DATA_W(DW), .MEM_DEPTH(DEPTH),
        .TON_CLKS(TON), .TOFF_CLKS(TOFF), .HOLD_CLKS(HOLD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .din(din), .ext_drv(ext_drv), .dout(dout),
        .dout_en(dout_en), .contention(contention)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 29 + 7);
    endfunction

    function automatic logic [AW-1:0] waddr(input int a);
        return AW'(a + (a % 3) * DEPTH);
    endfunction

    function automatic logic [AW-1:0] raddr(input int a);
        return AW'(a + (a % 2) * 2 * DEPTH);
    endfunction

    // write ended by we_n rising
    task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; din = d; cs_n = 1'b0; tick();
        we_n = 1'b0; tick(); tick();
        we_n = 1'b1; tick();
        cs_n = 1'b1; tick();
    endtask

    // write started and ended by cs_n
    task automatic wr_cs(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; din = d; we_n = 1'b0; tick();
        cs_n = 1'b0; tick(); tick();
        cs_n = 1'b1; tick();
        we_n = 1'b1; tick();
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (TON + 1) tick();
        check(req, int'(dout_en), 1);
        check(req, int'(dout), int'(exp));
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (TOFF + 1) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        din = '0; ext_drv = 1'b0;
        repeat (3) tick();
        check("R1 dout_en in reset", int'(dout_en), 0);
        check("R1 contention in reset", int'(contention), 0);
        rst_n = 1'b1; tick();
        check("R1 dout_en after reset", int'(dout_en), 0);
        check("R1 contention after reset", int'(contention), 0);

        // R3 R4: fill every location, alternating framing, aliased addresses
        for (int a = 0; a < DEPTH; a++) begin
            if (a % 2 == 1) wr_cs(waddr(a), pat(a));
            else            wr_we(waddr(a), pat(a));
        end

        // R5 turn-on count, from a released bus
        repeat (3) tick();
        addr = raddr(0); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick(); check("R5 off after 1 sample", int'(dout_en), 0);
        tick(); check("R5 off after 2 samples", int'(dout_en), 0);
        tick(); check("R5 on after TON samples", int'(dout_en), 1);
        check("R4 readback 0", int'(dout), int'(pat(0)));

        // R9 R4 R3: continuous read sweep with hold checks
        for (int a = 1; a < DEPTH; a++) begin
            addr = raddr(a);
            tick(); check("R9 hold sample 1", int'(dout), int'(pat(a - 1)));
            tick(); check("R9 hold sample 2", int'(dout), int'(pat(a - 1)));
            tick(); check("R4 R3 readback", int'(dout), int'(pat(a)));
        end

        // R6 turn-off count
        oe_n = 1'b1;
        tick(); check("R6 still on", int'(dout_en), 1);
        tick(); check("R6 off after TOFF", int'(dout_en), 0);
        cs_n = 1'b1; repeat (2) tick();

        // R2 single strobes write nothing
        addr = AW'(5); din = ~pat(5); we_n = 1'b0; cs_n = 1'b1;
        repeat (3) tick();
        we_n = 1'b1; tick();
        addr = AW'(6); din = ~pat(6); cs_n = 1'b0;
        repeat (3) tick();
        cs_n = 1'b1; tick();
        rd_chk(AW'(5), pat(5), "R2 we_n alone");
        rd_chk(AW'(6), pat(6), "R2 cs_n alone");

        // R3 last overlapping sample's byte is stored
        addr = AW'(9); din = 8'h11; cs_n = 1'b0; we_n = 1'b0; tick();
        din = 8'h22; tick();
        din = 8'h33; tick();
        din = 8'h44; we_n = 1'b1; tick();
        cs_n = 1'b1; tick();
        rd_chk(AW'(9), 8'h33, "R3 last byte");

        // R7 cs_n falls after we_n with oe_n low; R8 turn-on after write
        addr = AW'(12); din = 8'hA5; oe_n = 1'b0; we_n = 1'b0; cs_n = 1'b1;
        repeat (3) tick();
        cs_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick(); check("R7 released during write", int'(dout_en), 0);
        end
        we_n = 1'b1; din = 8'h00;
        tick(); check("R8 off sample 1", int'(dout_en), 0);
        tick(); check("R8 off sample 2", int'(dout_en), 0);
        tick(); check("R8 on", int'(dout_en), 1);
        check("R8 written byte", int'(dout), 8'hA5);

        // R7 both strobes fall together
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; repeat (3) tick();
        addr = AW'(13); din = 8'h5C; oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick(); check("R7 simultaneous fall", int'(dout_en), 0);
        end
        we_n = 1'b1; repeat (TON) tick();
        check("R8 simultaneous byte", int'(dout), 8'h5C);

        // R10 contention while driving and while released
        check("R10 idle", int'(contention), 0);
        ext_drv = 1'b1; tick(); check("R10 clash", int'(contention), 1);
        ext_drv = 1'b0; tick(); check("R10 clear", int'(contention), 0);
        oe_n = 1'b1; repeat (TOFF) tick();
        ext_drv = 1'b1; tick(); check("R10 released bus", int'(contention), 0);
        ext_drv = 1'b0; cs_n = 1'b1; tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule